// File: doc/BRIEF.md
# Host Command Mailbox with Completion Interrupt

This block is the register window through which a host hands one command at a time to an internal command executor. The host loads up to two argument words into DATA0 and DATA1. It then writes a command identifier into the combined status/command register. That write marks the mailbox busy and launches the executor with the identifier and both arguments. The executor reports back with a done pulse that carries an error flag, an error code and two result words.

On completion the mailbox captures the outcome into the data registers and drops busy. If the command write asked for it, the mailbox also latches a pending interrupt, and this drives the interrupt output. The pending interrupt stays set until the host writes the clear bit in a separate interrupt register. The host can either poll the busy bit or wait for the interrupt. The command semantics belong to the executor and are outside this block.

Top module: `cmd_mailbox`

## Requirements
- R1: After synchronous reset, busy, error, pending interrupt, `irq_o`, `exec_start`, both data registers and `host_rdata` are all zero.
- R2: A write to address 0 while not busy sets busy after that clock edge. In the same cycle `exec_start` is high for exactly one cycle. `exec_cmd_id` then holds write data bits [7:0], and `exec_arg0`/`exec_arg1` present DATA0/DATA1.
- R3: Busy stays high from the accepted command write until a cycle in which `exec_done` is high.
- R4: A write to address 0 while busy is ignored. It produces no `exec_start` and leaves `exec_cmd_id`, error and the interrupt request unchanged.
- R5: On `exec_done` with `exec_err` low while busy, DATA0 and DATA1 take `exec_res0`/`exec_res1` and the error bit stays clear. This happens on the same edge at which busy falls.
- R6: On `exec_done` with `exec_err` high while busy, the error bit is set, DATA0 takes `exec_err_code` and DATA1 keeps its value. This happens on the same edge at which busy falls.
- R7: If bit 28 of the accepted command write was 1, completion sets the pending bit and `irq_o` goes high on that edge.
- R8: If bit 28 of the accepted command write was 0, completion leaves the pending bit and `irq_o` low.
- R9: A write to address 3 with bit 0 set clears the pending bit and `irq_o`. A write there with bit 0 clear has no effect. When a completion and a clear land in the same cycle, the completion wins.
- R10: An accepted command write clears the error bit.
- R11: Reads are registered. `host_re` at an edge updates `host_rdata` on that edge.
  - Address 0 returns busy in bit 31, error in bit 30 and pending in bit 29, with the other bits zero.
  - Addresses 1 and 2 return DATA0 and DATA1.
  - Address 3 returns zero.
- R12: `exec_done` while not busy is ignored: the data registers, error and pending bits are unchanged. Host writes to DATA0/DATA1 take effect at any time, except that a same-cycle completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 status/command, 1 DATA0, 2 DATA1, 3 IRQ |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| exec_start | output | 1 | One-cycle launch pulse to the executor |
| exec_cmd_id | output | ID_W | Identifier of the launched command |
| exec_arg0 | output | DATA_W | First argument (DATA0) |
| exec_arg1 | output | DATA_W | Second argument (DATA1) |
| exec_done | input | 1 | Executor completion pulse |
| exec_err | input | 1 | Completion failed |
| exec_err_code | input | DATA_W | Error code on failure |
| exec_res0 | input | DATA_W | First result word |
| exec_res1 | input | DATA_W | Second result word |
| irq_o | output | 1 | Completion interrupt, active high |

## Verification
Every result in this block is due exactly one clock edge after its cause:
- busy, `exec_start`, the identifier and the error clear follow the command write.
- captured results, the error bit and `irq_o` follow the done pulse.
- a cleared `irq_o` follows the IRQ write.
- `host_rdata` follows the read strobe.

The bench drives its stimulus on falling edges and advances a behavioural model on each rising edge. It compares every output against that model on the next falling edge, so each expected value is sampled in the first cycle it should be visible. Directed reads then confirm busy persistence, rejected commands, error capture and interrupt clearing through the register interface.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_DATA0  = 2'd1,
    REG_DATA1  = 2'd2,
    REG_IRQ    = 2'd3
  } mbx_reg_e;

  localparam int BUSY_BIT   = 31;
  localparam int ERR_BIT    = 30;
  localparam int PEND_BIT   = 29;
  localparam int IRQREQ_BIT = 28;
  localparam int CLR_BIT    = 0;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic              fail,
  output logic              finish,
  output logic              busy,
  output logic              err,
  output logic              pend,
  output logic              start,
  output logic [ID_W-1:0]   cmd_id
);
  logic accept;
  logic irq_req;

  assign accept = cmd_wr && !busy;
  assign finish = done && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      err     <= 1'b0;
      pend    <= 1'b0;
      start   <= 1'b0;
      irq_req <= 1'b0;
      cmd_id  <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        busy    <= 1'b1;
        err     <= 1'b0;
        irq_req <= wdata[IRQREQ_BIT];
        cmd_id  <= wdata[ID_W-1:0];
      end
      if (clr_wr && wdata[CLR_BIT]) pend <= 1'b0;
      if (finish) begin
        busy <= 1'b0;
        err  <= fail;
        if (irq_req) pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wdata,
  input  logic              finish,
  input  logic              fail,
  input  logic [DATA_W-1:0] code,
  input  logic [DATA_W-1:0] res0,
  input  logic [DATA_W-1:0] res1,
  output logic [DATA_W-1:0] data0,
  output logic [DATA_W-1:0] data1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data0 <= '0;
      data1 <= '0;
    end else if (finish) begin
      if (fail) begin
        data0 <= code;
      end else begin
        data0 <= res0;
        data1 <= res1;
      end
    end else begin
      if (wr0) data0 <= wdata;
      if (wr1) data1 <= wdata;
    end
  end
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [1:0]        addr,
  input  logic              busy,
  input  logic              err,
  input  logic              pend,
  input  logic [DATA_W-1:0] data0,
  input  logic [DATA_W-1:0] data1,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] sel;

  always_comb begin
    status_w           = '0;
    status_w[BUSY_BIT] = busy;
    status_w[ERR_BIT]  = err;
    status_w[PEND_BIT] = pend;
    case (mbx_reg_e'(addr))
      REG_STATUS: sel = status_w;
      REG_DATA0:  sel = data0;
      REG_DATA1:  sel = data1;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= sel;
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              exec_start,
  output logic [ID_W-1:0]   exec_cmd_id,
  output logic [DATA_W-1:0] exec_arg0,
  output logic [DATA_W-1:0] exec_arg1,
  input  logic              exec_done,
  input  logic              exec_err,
  input  logic [DATA_W-1:0] exec_err_code,
  input  logic [DATA_W-1:0] exec_res0,
  input  logic [DATA_W-1:0] exec_res1,
  output logic              irq_o
);
  logic busy, err, pend, finish;
  logic cmd_wr, clr_wr, wr0, wr1;
  logic [DATA_W-1:0] data0, data1;

  assign cmd_wr = host_we && (mbx_reg_e'(host_addr) == REG_STATUS);
  assign clr_wr = host_we && (mbx_reg_e'(host_addr) == REG_IRQ);
  assign wr0    = host_we && (mbx_reg_e'(host_addr) == REG_DATA0);
  assign wr1    = host_we && (mbx_reg_e'(host_addr) == REG_DATA1);

  mbx_ctrl #(.DATA_W(DATA_W), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .clr_wr(clr_wr), .wdata(host_wdata),
    .done(exec_done), .fail(exec_err), .finish(finish), .busy(busy), .err(err),
    .pend(pend), .start(exec_start), .cmd_id(exec_cmd_id)
  );

  mbx_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr0(wr0), .wr1(wr1), .wdata(host_wdata),
    .finish(finish), .fail(exec_err), .code(exec_err_code),
    .res0(exec_res0), .res1(exec_res1), .data0(data0), .data1(data1)
  );

  mbx_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .re(host_re), .addr(host_addr), .busy(busy),
    .err(err), .pend(pend), .data0(data0), .data1(data1), .rdata(host_rdata)
  );

  assign exec_arg0 = data0;
  assign exec_arg1 = data1;
  assign irq_o     = pend;
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              host_we,
  input logic [1:0]        host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              exec_done,
  input logic              exec_err,
  input logic [DATA_W-1:0] exec_err_code,
  input logic              exec_start,
  input logic [DATA_W-1:0] exec_arg0,
  input logic              irq_o,
  input logic              busy,
  input logic              err
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> busy);
  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !exec_done) |=> busy);
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> !exec_start);
  assert_ok_done_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && exec_done && !exec_err) |=> (!busy && !err));
  assert_fail_done_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && exec_done && exec_err) |=> (!busy && err && exec_arg0 == $past(exec_err_code)));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(busy) && $past(exec_done)));
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 2'd3 && host_wdata[0] && !(busy && exec_done)) |=> !irq_o);
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .exec_done(exec_done), .exec_err(exec_err),
  .exec_err_code(exec_err_code), .exec_start(exec_start), .exec_arg0(exec_arg0),
  .irq_o(irq_o), .busy(busy), .err(err)
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
  localparam int DW = 32;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic exec_start;
  logic [IW-1:0] exec_cmd_id;
  logic [DW-1:0] exec_arg0, exec_arg1;
  logic exec_done = 1'b0, exec_err = 1'b0;
  logic [DW-1:0] exec_err_code = '0, exec_res0 = '0, exec_res1 = '0;
  logic irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  cmd_mailbox #(.DATA_W(DW), .ID_W(IW)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .exec_start(exec_start), .exec_cmd_id(exec_cmd_id), .exec_arg0(exec_arg0),
    .exec_arg1(exec_arg1), .exec_done(exec_done), .exec_err(exec_err),
    .exec_err_code(exec_err_code), .exec_res0(exec_res0), .exec_res1(exec_res1),
    .irq_o(irq_o)
  );

  // behavioural reference model
  bit m_busy, m_err, m_pend, m_req, m_start;
  logic [IW-1:0] m_id;
  logic [DW-1:0] m_d0, m_d1, m_rd;

  always @(posedge clk) begin
    bit ob;
    if (rst) begin
      m_busy = 0; m_err = 0; m_pend = 0; m_req = 0; m_start = 0;
      m_id = '0; m_d0 = '0; m_d1 = '0; m_rd = '0;
    end else begin
      ob = m_busy;
      if (host_re) begin
        if (host_addr == 2'd0) m_rd = {m_busy, m_err, m_pend, 29'd0};
        else if (host_addr == 2'd1) m_rd = m_d0;
        else if (host_addr == 2'd2) m_rd = m_d1;
        else m_rd = '0;
      end
      m_start = 0;
      if (host_we) begin
        if (host_addr == 2'd0 && !ob) begin
          m_busy = 1; m_err = 0; m_req = host_wdata[28];
          m_id = host_wdata[IW-1:0]; m_start = 1;
        end else if (host_addr == 2'd1) m_d0 = host_wdata;
        else if (host_addr == 2'd2) m_d1 = host_wdata;
        else if (host_addr == 2'd3 && host_wdata[0]) m_pend = 0;
      end
      if (exec_done && ob) begin
        m_busy = 0; m_err = exec_err;
        if (exec_err) m_d0 = exec_err_code;
        else begin m_d0 = exec_res0; m_d1 = exec_res1; end
        if (m_req) m_pend = 1;
      end
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R11 rdata", host_rdata, m_rd);
      check("R7 irq_o", {31'd0, irq_o}, {31'd0, m_pend});
      check("R2 exec_start", {31'd0, exec_start}, {31'd0, m_start});
      check("R2 exec_cmd_id", {24'd0, exec_cmd_id}, {24'd0, m_id});
      check("R2 exec_arg0", exec_arg0, m_d0);
      check("R2 exec_arg1", exec_arg1, m_d1);
    end
    if (cycles > 5000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] v);
    @(negedge clk); host_re = 1; host_addr = a;
    @(negedge clk); host_re = 0; v = host_rdata;
  endtask

  task automatic finish_cmd(logic e, logic [DW-1:0] c, logic [DW-1:0] r0, logic [DW-1:0] r1);
    @(negedge clk); exec_done = 1; exec_err = e; exec_err_code = c;
    exec_res0 = r0; exec_res1 = r1;
    @(negedge clk); exec_done = 0; exec_err = 0;
  endtask

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 start", {31'd0, exec_start}, 32'd0);
    check("R1 arg0", exec_arg0, 32'd0);
    rd(2'd0, v); check("R1 status", v, 32'd0);

    // R2 launch without interrupt
    wr(2'd1, 32'hAAAA_0001);
    wr(2'd2, 32'hBBBB_0002);
    wr(2'd0, 32'h0000_0012);
    check("R2 start pulse", {31'd0, exec_start}, 32'd1);
    check("R2 id", {24'd0, exec_cmd_id}, 32'h12);
    check("R2 arg1", exec_arg1, 32'hBBBB_0002);
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R3 busy held", v, 32'h8000_0000);
    // R4 second command while busy
    wr(2'd0, 32'h1000_0077);
    check("R4 no restart", {31'd0, exec_start}, 32'd0);
    check("R4 id kept", {24'd0, exec_cmd_id}, 32'h12);
    finish_cmd(1'b0, 32'h0, 32'h1111_2222, 32'h3333_4444);
    rd(2'd1, v); check("R5 data0", v, 32'h1111_2222);
    rd(2'd2, v); check("R5 data1", v, 32'h3333_4444);
    rd(2'd0, v); check("R8 status no irq", v, 32'h0);
    check("R8 irq low", {31'd0, irq_o}, 32'd0);

    // R7 launch with interrupt, failure
    wr(2'd0, 32'h1000_0034);
    finish_cmd(1'b1, 32'h0000_0055, 32'hDEAD_0000, 32'hDEAD_0001);
    check("R7 irq high", {31'd0, irq_o}, 32'd1);
    rd(2'd0, v); check("R6 status err+pend", v, 32'h6000_0000);
    rd(2'd1, v); check("R6 code", v, 32'h0000_0055);
    rd(2'd2, v); check("R6 data1 kept", v, 32'h3333_4444);
    wr(2'd3, 32'h0000_0002);
    check("R9 no clear", {31'd0, irq_o}, 32'd1);
    wr(2'd3, 32'h0000_0001);
    check("R9 cleared", {31'd0, irq_o}, 32'd0);

    // R10 new command clears error
    wr(2'd0, 32'h0000_0009);
    rd(2'd0, v); check("R10 err cleared", v, 32'h8000_0000);
    // R9 completion and clear together: completion wins
    wr(2'd0, 32'h1000_0000);
    finish_cmd(1'b0, 32'h0, 32'h5, 32'h6);
    wr(2'd0, 32'h1000_0003);
    @(negedge clk);
    host_we = 1; host_addr = 2'd3; host_wdata = 32'h1; exec_done = 1;
    exec_res0 = 32'h7; exec_res1 = 32'h8;
    @(negedge clk); host_we = 0; exec_done = 0;
    check("R9 set wins", {31'd0, irq_o}, 32'd1);
    wr(2'd3, 32'h1);

    // R12 done while idle, host data write
    finish_cmd(1'b1, 32'hFFFF_FFFF, 32'h9, 32'h9);
    rd(2'd1, v); check("R12 data0 kept", v, 32'h7);
    rd(2'd0, v); check("R12 status", v, 32'h0);
    wr(2'd2, 32'hCAFE_F00D);
    rd(2'd2, v); check("R12 data1 write", v, 32'hCAFE_F00D);
    rd(2'd3, v); check("R11 irq reads zero", v, 32'h0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule